// File: doc/BRIEF.md
# Single-Precision Compare Unit with Exception Flags

This block compares two binary32 floating-point values per lane under a 3-bit predicate code. Each lane returns a 32-bit mask that is all ones when the predicate holds and all zeros when it does not. Two lanes are evaluated in packed mode; only lane 0 is evaluated in scalar mode. An internal control/status word holds sticky invalid and denormal flags, a mask bit for each, and a denormals-as-zero enable.

An issue pulse samples the operands. One clock later the compare mask appears in the result register and the sticky flags are updated. If an exception is raised whose mask bit is clear, a one-cycle fault pulse is given and the result register keeps its previous contents. Software reads the control word on `csr_q` and rewrites it through `csr_wr`/`csr_wdata`.

Top module: `fpcmp_unit`

## Requirements
- R1: After reset, `result` is 0, `fault` is 0 and `csr_q` is 16'h0180 (both mask bits set, flags and denormals-as-zero clear).
- R2: Predicate codes are 0=EQ, 1=LT, 2=LE, 3=UNORD, 4=NEQ, 5=NLT, 6=NLE, 7=ORD. Lane i uses bits [32i+31:32i] of `op_a`, `op_b` and `result`. The lane result is 32'hFFFFFFFF when the predicate holds for a compared with b, and 0 otherwise, under ordinary signed ordering.
- R3: +0 and -0 compare equal, and neither is less than the other.
- R4: An operand is a NaN when exponent bits [30:23] are all ones and fraction [22:0] is nonzero. A compare that involves a NaN is unordered: EQ, LT, LE and ORD give false, and NEQ, NLT, NLE and UNORD give true.
- R5: A NaN with fraction bit 22 clear is signalling and always sets the invalid flag (bit 0). A NaN with bit 22 set is quiet and sets the invalid flag only under LT, LE, NLT or NLE. Invalid detection does not depend on bit 6.
- R6: With bit 6 clear, a denormal operand (exponent 0, fraction nonzero) sets the denormal flag (bit 1), unless the same issue raises invalid.
- R7: With bit 6 set, a denormal operand is compared as a zero of its own sign and sets no denormal flag.
- R8: An invalid raised while mask bit 7 is 0, or a denormal raised while mask bit 8 is 0, produces `fault` high for exactly the cycle after the issue. The whole result register is left unchanged and the flag is still set.
- R9: Flags are sticky and change only through a `csr_wr` write, which loads `csr_wdata`. Flags raised by an issue in the same cycle are ORed into the written value, while that issue uses the old masks and mode.
- R10: In scalar mode (`packed_mode`=0), lane 0 alone is compared. Lane 1 of `result` keeps its value, and lane 1 operands raise no flag and no fault.
- R11: Results and flags appear one clock after the issue. Without an issue, `result` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Start a compare with the current inputs |
| packed_mode | input | 1 | 1: both lanes, 0: lane 0 only |
| pred | input | 3 | Predicate code |
| op_a | input | 64 | First operand, two binary32 lanes |
| op_b | input | 64 | Second operand, two binary32 lanes |
| csr_wr | input | 1 | Load control/status word |
| csr_wdata | input | 16 | Value to load |
| result | output | 64 | Per-lane compare masks |
| fault | output | 1 | Unmasked exception pulse |
| csr_q | output | 16 | Control/status word |

## Verification
Every result is due one clock after the edge that samples `issue`: the compare mask, the sticky flags and the fault pulse all come from that single register stage. The bench drives on the falling edge and samples on the following falling edge, so exactly one rising edge lies between stimulus and check. For a fault the bench also confirms that the pulse has dropped one cycle later, and for suppressed writes it confirms that the result written before the fault is still present.

// File: rtl/fpcmp_unit.sv
module fpcmp_unit #(
  parameter int LANES = 2,
  parameter int CSR_W = 16,
  parameter logic [CSR_W-1:0] CSR_RESET = 16'h0180
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue,
  input  logic               packed_mode,
  input  logic [2:0]         pred,
  input  logic [32*LANES-1:0] op_a,
  input  logic [32*LANES-1:0] op_b,
  input  logic               csr_wr,
  input  logic [CSR_W-1:0]   csr_wdata,
  output logic [32*LANES-1:0] result,
  output logic               fault,
  output logic [CSR_W-1:0]   csr_q
);
  localparam int B_IF  = 0;
  localparam int B_DF  = 1;
  localparam int B_DAZ = 6;
  localparam int B_IM  = 7;
  localparam int B_DM  = 8;

  localparam logic [2:0] C_EQ = 3'd0, C_LT = 3'd1, C_LE = 3'd2, C_UN = 3'd3,
                         C_NE = 3'd4, C_NLT = 3'd5, C_NLE = 3'd6, C_ORD = 3'd7;

  wire daz      = csr_q[B_DAZ];
  wire sig_pred = (pred == C_LT) || (pred == C_LE) || (pred == C_NLT) || (pred == C_NLE);

  logic [LANES-1:0] hit, inv_v, den_v;
  logic [31:0]      res_q [LANES];

  wire inv_hit = |inv_v;
  wire den_hit = |den_v & ~inv_hit;
  wire fault_d = issue & ((inv_hit & ~csr_q[B_IM]) | (den_hit & ~csr_q[B_DM]));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wire [31:0] ra = op_a[32*i +: 32];
    wire [31:0] rb = op_b[32*i +: 32];
    wire on    = packed_mode | (i == 0);

    wire a_nan = (&ra[30:23]) & (|ra[22:0]);
    wire b_nan = (&rb[30:23]) & (|rb[22:0]);
    wire a_den = ~(|ra[30:23]) & (|ra[22:0]);
    wire b_den = ~(|rb[30:23]) & (|rb[22:0]);
    wire snan  = (a_nan & ~ra[22]) | (b_nan & ~rb[22]);
    wire qnan  = (a_nan & ra[22]) | (b_nan & rb[22]);

    wire [31:0] xa = (daz & a_den) ? {ra[31], 31'd0} : ra;
    wire [31:0] xb = (daz & b_den) ? {rb[31], 31'd0} : rb;

    wire un    = a_nan | b_nan;
    wire zz    = ~(|xa[30:0]) & ~(|xb[30:0]);
    wire eq    = (xa == xb) | zz;
    logic lt;
    always_comb begin
      if (xa[31] != xb[31]) lt = xa[31] & ~zz;
      else if (!xa[31])     lt = xa[30:0] < xb[30:0];
      else                  lt = xa[30:0] > xb[30:0];
    end

    always_comb begin
      case (pred)
        C_EQ:    hit[i] = ~un & eq;
        C_LT:    hit[i] = ~un & lt;
        C_LE:    hit[i] = ~un & (lt | eq);
        C_UN:    hit[i] = un;
        C_NE:    hit[i] = un | ~eq;
        C_NLT:   hit[i] = un | ~lt;
        C_NLE:   hit[i] = un | ~(lt | eq);
        default: hit[i] = ~un;
      endcase
    end

    assign inv_v[i] = on & (snan | (qnan & sig_pred));
    assign den_v[i] = on & ~daz & (a_den | b_den);

    always_ff @(posedge clk) begin
      if (!rst_n)                   res_q[i] <= '0;
      else if (issue & on & ~fault_d) res_q[i] <= {32{hit[i]}};
    end

    assign result[32*i +: 32] = res_q[i];
  end

  logic [CSR_W-1:0] raise;
  always_comb begin
    raise = '0;
    raise[B_IF] = issue & inv_hit;
    raise[B_DF] = issue & den_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q <= CSR_RESET;
      fault <= 1'b0;
    end else begin
      csr_q <= (csr_wr ? csr_wdata : csr_q) | raise;
      fault <= fault_d;
    end
  end

  p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> result == $past(result));

  p_fault_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (csr_q[B_IF] | csr_q[B_DF]));

  p_sticky_inv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(csr_q[B_IF]) && !$past(csr_wr)) |-> csr_q[B_IF]);

  p_sticky_den_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(csr_q[B_DF]) && !$past(csr_wr)) |-> csr_q[B_DF]);

  p_daz_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(csr_q[B_DF]) && !$past(csr_wr)) |-> !$past(csr_q[B_DAZ]));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(issue) |-> $stable(result));
endmodule

// File: tb/sim_fpcmp_unit.sv
module sim_fpcmp_unit;
  logic        clk = 0, rst_n = 0, issue = 0, packed_mode = 0, csr_wr = 0;
  logic [2:0]  pred = 0;
  logic [63:0] op_a = 0, op_b = 0;
  logic [15:0] csr_wdata = 0;
  logic [63:0] result;
  logic        fault;
  logic [15:0] csr_q;

  fpcmp_unit u0 (.clk(clk), .rst_n(rst_n), .issue(issue), .packed_mode(packed_mode),
    .pred(pred), .op_a(op_a), .op_b(op_b), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .result(result), .fault(fault), .csr_q(csr_q));

  always #10 clk = ~clk;

  localparam logic [2:0] EQ = 0, LT = 1, LE = 2, UN = 3, NE = 4, NLT = 5, NLE = 6, ORD = 7;
  localparam logic [31:0] ONE = 32'h3F800000, TWO = 32'h40000000, M1 = 32'hBF800000,
    M2 = 32'hC0000000, PZ = 32'h0, MZ = 32'h80000000, QN = 32'h7FC00000,
    SN = 32'h7F800001, DN = 32'h00000001, MDN = 32'h80000001, INF = 32'h7F800000;
  localparam int NV = 26;
  localparam logic [69:0] VEC [NV] = '{
    {EQ, ONE, ONE, 3'b100}, {EQ, ONE, TWO, 3'b000}, {LT, ONE, TWO, 3'b100},
    {LT, TWO, ONE, 3'b000}, {LT, M1, ONE, 3'b100},  {LE, ONE, ONE, 3'b100},
    {LT, M1, M2, 3'b000},   {NLT, TWO, ONE, 3'b100}, {NLE, ONE, ONE, 3'b000},
    {NE, ONE, TWO, 3'b100}, {ORD, ONE, TWO, 3'b100}, {UN, ONE, TWO, 3'b000},
    {EQ, PZ, MZ, 3'b100},   {LT, MZ, PZ, 3'b000},   {LE, MZ, PZ, 3'b100},
    {EQ, QN, QN, 3'b000},   {NE, QN, ONE, 3'b100},  {UN, ONE, QN, 3'b100},
    {NLT, QN, ONE, 3'b110}, {LT, QN, ONE, 3'b010},  {ORD, QN, ONE, 3'b000},
    {LT, ONE, INF, 3'b100}, {LT, PZ, DN, 3'b101},   {EQ, SN, ONE, 3'b010},
    {LT, QN, DN, 3'b010},   {NLE, M2, M1, 3'b000}
  };

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_issue(input logic pm, input logic [2:0] p, input logic [63:0] a, input logic [63:0] b);
    packed_mode = pm; pred = p; op_a = a; op_b = b; issue = 1;
    @(negedge clk); issue = 0;
  endtask

  task automatic wr_csr(input logic [15:0] v);
    csr_wdata = v; csr_wr = 1;
    @(negedge clk); csr_wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 result", result, 64'h0);
    check("R1 fault", {63'h0, fault}, 64'h0);
    check("R1 csr", {48'h0, csr_q}, 64'h0180);

    for (int i = 0; i < NV; i++) begin
      wr_csr(16'h0180);
      do_issue(1'b1, VEC[i][69:67], {2{VEC[i][66:35]}}, {2{VEC[i][34:3]}});
      check($sformatf("R2/R3/R4 vec %0d result", i), result, {64{VEC[i][2]}});
      check($sformatf("R5/R6 vec %0d flags", i), {62'h0, csr_q[1:0]}, {62'h0, VEC[i][0], VEC[i][1]});
    end

    wr_csr(16'h01C0);
    do_issue(1'b1, LT, {2{MDN}}, {2{PZ}});
    check("R7 daz lt", result, 64'h0);
    do_issue(1'b1, EQ, {2{MDN}}, {2{PZ}});
    check("R7 daz eq", result, {64{1'b1}});
    check("R7 daz no flag", {48'h0, csr_q}, 64'h01C0);
    do_issue(1'b1, EQ, {2{SN}}, {2{DN}});
    check("R5 invalid with daz", {48'h0, csr_q}, 64'h01C1);
    wr_csr(16'h0180);
    do_issue(1'b1, EQ, {2{MDN}}, {2{PZ}});
    check("R6 no daz eq", result, 64'h0);
    check("R6 no daz flag", {48'h0, csr_q}, 64'h0182);

    wr_csr(16'h0100);
    do_issue(1'b1, EQ, {2{ONE}}, {2{ONE}});
    check("R8 setup", result, {64{1'b1}});
    do_issue(1'b1, LT, {2{QN}}, {2{ONE}});
    check("R8 fault inv", {63'h0, fault}, 64'h1);
    check("R8 result kept", result, {64{1'b1}});
    check("R8 inv flag", {48'h0, csr_q}, 64'h0101);
    @(negedge clk);
    check("R8 pulse one cycle", {63'h0, fault}, 64'h0);
    check("R9 sticky", {48'h0, csr_q}, 64'h0101);
    do_issue(1'b1, EQ, {2{QN}}, {2{ONE}});
    check("R5 quiet eq no fault", {63'h0, fault}, 64'h0);
    check("R9 sticky after clean issue", {48'h0, csr_q}, 64'h0101);
    wr_csr(16'h0100);
    check("R9 write clears", {48'h0, csr_q}, 64'h0100);

    wr_csr(16'h0080);
    do_issue(1'b1, LT, {2{DN}}, {2{ONE}});
    check("R8 fault den", {63'h0, fault}, 64'h1);
    check("R8 den result kept", result, 64'h0);
    check("R8 den flag", {48'h0, csr_q}, 64'h0082);

    packed_mode = 1; pred = EQ; op_a = {2{SN}}; op_b = {2{ONE}}; issue = 1;
    csr_wdata = 16'h0180; csr_wr = 1;
    @(negedge clk); issue = 0; csr_wr = 0;
    check("R9 write plus issue", {48'h0, csr_q}, 64'h0181);
    check("R9 old mask no fault", {63'h0, fault}, 64'h0);

    wr_csr(16'h0180);
    do_issue(1'b1, LT, {TWO, ONE}, {ONE, TWO});
    check("R2 packed lanes", result, 64'h00000000_FFFFFFFF);
    do_issue(1'b1, EQ, {2{ONE}}, {2{ONE}});
    wr_csr(16'h0000);
    do_issue(1'b0, EQ, {SN, ONE}, {ONE, TWO});
    check("R10 scalar result", result, 64'hFFFFFFFF_00000000);
    check("R10 no fault", {63'h0, fault}, 64'h0);
    check("R10 no flag", {48'h0, csr_q}, 64'h0000);

    op_a = {2{TWO}}; op_b = {2{ONE}}; pred = NE; packed_mode = 1;
    repeat (2) @(negedge clk);
    check("R11 idle hold", result, 64'hFFFFFFFF_00000000);
    do_issue(1'b1, NE, {2{TWO}}, {2{ONE}});
    check("R11 one cycle", result, {64{1'b1}});

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule